// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Synchronous SRAM

This block models a single-port synchronous SRAM with a common data bus, split into input, output and output-enable signals. All control inputs are registered on a qualified rising clock edge. Read data flows straight from the array to the output in the cycle after the command edge, with no output register. Write data follows its address by one qualified edge. Because of this, a stream of mixed reads and writes runs at one access per cycle with no idle cycle at a direction change.

A command edge with advance/load low loads a new address and starts a read or a write. A command edge with advance/load high continues the current access on the next address of a four-beat burst. The burst order is linear or interleaved, chosen by a parameter. Each write lane is nine bits wide (eight data bits and one parity bit) and is gated by its own active-low byte select. A high clock enable freezes the block. The output drivers are masked by internal state whatever the output enable does.

The controller has three states: `ST_DESEL`, `ST_READ` and `ST_WRITE`. On a qualified edge the transitions are:
- LOAD_READ: a load with the device selected and write enable high, entering `ST_READ`.
- LOAD_WRITE: a load with the device selected and write enable low, entering `ST_WRITE`.
- DESELECT: a load with the device not selected, entering `ST_DESEL`.
- CONTINUE: advance/load high, which keeps the current state.

HOLD is an unqualified edge, and every state stays as it was.

Top module: `zt_flow_sram`

## Requirements
- R1: Reset puts the block in `ST_DESEL`, drops any pending write and holds `dq_oe` low. A write whose data edge has not yet come before reset never reaches the array.
- R2: An edge with `cke_n` high changes no state, address or array word, and the outputs hold. A pending write takes its data at the next edge with `cke_n` low.
- R3: The device is selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0 at a load edge (`adv_ld`=0). Any other combination deselects it, and the write data that would have followed is not stored.
- R4: After a load edge with `we_n`=1, `dq_out` shows the word at the loaded address during the next cycle, with no extra register stage.
- R5: A load edge with `we_n`=0 captures the address and `bsel_n`. At the next qualified edge, `dq_in` is written to that address. Lane l is bits [9l+8:9l], and it is written only if `bsel_n[l]`=0.
- R6: `dq_oe` is low in the data cycle of a write and while deselected, including the first cycle after a deselect edge, even with `oe_n`=0.
- R7: In a read cycle, `dq_oe` follows `oe_n` (active low) combinationally, without waiting for a clock.
- R8: A read issued on the edge that takes a write's data, to the same address, returns the new lanes merged with the old contents of the unselected lanes.
- R9: With `INTERLEAVE`=0, edges with `adv_ld`=1 in `ST_READ` or `ST_WRITE` repeat the operation. The low two address bits run start+n mod 4. `we_n` and the chip enables are ignored on these edges, while `bsel_n` is sampled on every edge.
- R10: An edge with `adv_ld`=1 in `ST_DESEL` keeps the block deselected and performs no array access.
- R11: With `INTERLEAVE`=1, the low two address bits of beat n are start XOR n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | AW | Word address, used at load edges |
| we_n | input | 1 | Write enable, active low |
| bsel_n | input | LANES | Per-lane byte write selects, active low |
| cs1_n | input | 1 | Chip enable, active low |
| cs2 | input | 1 | Chip enable, active high |
| cs3_n | input | 1 | Chip enable, active low |
| adv_ld | input | 1 | 0 loads a new address, 1 continues the burst |
| cke_n | input | 1 | Clock enable, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | 9*LANES | Write data from the bus |
| dq_out | output | 9*LANES | Read data to the bus |
| dq_oe | output | 1 | Bus driver enable |

## Verification
The bench covers several hazards and the failure each one would expose:
- **Same-address turnaround.** The bench sweeps all sixteen byte-select patterns with a read issued right after each write to the same address. A design that takes write data on the address edge, or that ignores lane masks, returns stale or over-written lanes.
- **Stalls.** Stalls are placed inside both a read and a pending write. A block that lets an unqualified edge through moves its address or stores the junk data present during the stall.
- **Chip-enable decode and deselect.** All eight chip-enable combinations are tried, along with continue edges while deselected. Either would drive the bus or write the array when it must not.
- **Bursts.** Bursts are run from a non-zero start through both orders, with mid-burst byte-select changes and junk on `we_n` and the chip enables. These catch wrong wrap, wrong order, or controls that are sampled when they should be ignored.

// File: rtl/zt_pkg.sv
package zt_pkg;
    localparam int LANE_BITS = 9;

    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } zt_state_e;
endpackage

// File: rtl/zt_lane_mem.sv
module zt_lane_mem #(
    parameter int AW    = 6,
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    // flow-through: array output goes straight to the port
    assign rdata = mem[addr];
endmodule

// File: rtl/zt_burst_addr.sv
module zt_burst_addr #(
    parameter int AW         = 6,
    parameter int BURST_BITS = 2,
    parameter bit INTERLEAVE = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          advance,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_eff
);
    logic [AW-1:0]         base_q;
    logic [BURST_BITS-1:0] cnt_q;
    logic [BURST_BITS-1:0] low_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            base_q <= addr_in;
            cnt_q  <= '0;
        end else if (advance) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    generate
        if (INTERLEAVE) begin : g_ilv
            assign low_bits = base_q[BURST_BITS-1:0] ^ cnt_q;
        end else begin : g_lin
            assign low_bits = base_q[BURST_BITS-1:0] + cnt_q;
        end
    endgenerate

    assign addr_eff = {base_q[AW-1:BURST_BITS], low_bits};
endmodule

// File: rtl/zt_ctrl.sv
module zt_ctrl
    import zt_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke_n,
    input  logic             adv_ld,
    input  logic             we_n,
    input  logic             sel,
    input  logic [LANES-1:0] bsel_n,
    output zt_state_e        state,
    output logic             load,
    output logic             advance,
    output logic [LANES-1:0] lane_we
);
    zt_state_e        state_q, state_d;
    logic [LANES-1:0] bsel_q;
    logic             qual;

    assign qual = !cke_n;

    // next state: LOAD_READ, LOAD_WRITE, DESELECT, CONTINUE, HOLD
    always_comb begin
        state_d = state_q;
        if (qual) begin
            if (!adv_ld) begin
                if (!sel)       state_d = ST_DESEL;
                else if (we_n)  state_d = ST_READ;
                else            state_d = ST_WRITE;
            end else begin
                unique case (state_q)
                    ST_DESEL: state_d = ST_DESEL;
                    ST_READ:  state_d = ST_READ;
                    ST_WRITE: state_d = ST_WRITE;
                    default:  state_d = ST_DESEL;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DESEL;
            bsel_q  <= '1;
        end else if (qual) begin
            state_q <= state_d;
            bsel_q  <= bsel_n;
        end
    end

    always_comb begin
        state   = state_q;
        load    = qual && !adv_ld && sel;
        advance = qual && adv_ld && (state_q != ST_DESEL);
        lane_we = (qual && state_q == ST_WRITE) ? ~bsel_q : '0;
    end

    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> $stable(state_q)); // R2

    AST_DESEL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DESEL && adv_ld && !cke_n) |=> (state_q == ST_DESEL)); // R10
endmodule

// File: rtl/zt_flow_sram.sv
module zt_flow_sram
    import zt_pkg::*;
#(
    parameter int AW         = 6,
    parameter int LANES      = 4,
    parameter int BURST_BITS = 2,
    parameter bit INTERLEAVE = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [AW-1:0]              addr,
    input  logic                       we_n,
    input  logic [LANES-1:0]           bsel_n,
    input  logic                       cs1_n,
    input  logic                       cs2,
    input  logic                       cs3_n,
    input  logic                       adv_ld,
    input  logic                       cke_n,
    input  logic                       oe_n,
    input  logic [LANES*LANE_BITS-1:0] dq_in,
    output logic [LANES*LANE_BITS-1:0] dq_out,
    output logic                       dq_oe
);
    localparam int DW = LANES * LANE_BITS;

    zt_state_e        state;
    logic             sel, load, advance;
    logic [LANES-1:0] lane_we;
    logic [AW-1:0]    addr_eff;

    assign sel = !cs1_n && cs2 && !cs3_n;

    zt_ctrl #(.LANES(LANES)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cke_n   (cke_n),
        .adv_ld  (adv_ld),
        .we_n    (we_n),
        .sel     (sel),
        .bsel_n  (bsel_n),
        .state   (state),
        .load    (load),
        .advance (advance),
        .lane_we (lane_we)
    );

    zt_burst_addr #(
        .AW         (AW),
        .BURST_BITS (BURST_BITS),
        .INTERLEAVE (INTERLEAVE)
    ) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .advance  (advance),
        .addr_in  (addr),
        .addr_eff (addr_eff)
    );

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            zt_lane_mem #(.AW(AW), .WIDTH(LANE_BITS)) u_mem (
                .clk   (clk),
                .we    (lane_we[l]),
                .addr  (addr_eff),
                .wdata (dq_in[l*LANE_BITS +: LANE_BITS]),
                .rdata (dq_out[l*LANE_BITS +: LANE_BITS])
            );
        end
    endgenerate

    // drivers only in a read data cycle; oe_n acts without a clock
    assign dq_oe = (state == ST_READ) && !oe_n;

    AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_we) |-> !dq_oe); // R6

    AST_SELECT_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv_ld && !(!cs1_n && cs2 && !cs3_n)) |=> (state == ST_DESEL)); // R3

    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv_ld && !cs1_n && cs2 && !cs3_n) |=> (addr_eff == $past(addr))); // R4

    logic unused_dw;
    assign unused_dw = (DW == 0);
endmodule

// File: tb/zt_flow_sram_bench.sv
module zt_flow_sram_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 6;
    localparam int LANES = 4;
    localparam int DW    = LANES * 9;
    localparam logic [2:0] SEL = 3'b010;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic           rst_n, we_n, cs1_n, cs2, cs3_n, adv_ld, cke_n, oe_n;
    logic [AW-1:0]  addr;
    logic [3:0]     bsel_n;
    logic [DW-1:0]  dq_in, dq_out_l, dq_out_i;
    logic           dq_oe_l, dq_oe_i;

    logic [DW-1:0]  m_lin [64];
    logic [DW-1:0]  m_il  [64];
    int total = 0;
    int bad   = 0;

    zt_flow_sram #(.AW(AW), .LANES(LANES), .BURST_BITS(2), .INTERLEAVE(1'b0)) u_zt_flow_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .we_n(we_n), .bsel_n(bsel_n),
        .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .adv_ld(adv_ld), .cke_n(cke_n),
        .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out_l), .dq_oe(dq_oe_l));

    zt_flow_sram #(.AW(AW), .LANES(LANES), .BURST_BITS(2), .INTERLEAVE(1'b1)) u_zt_flow_sram_il (
        .clk(clk), .rst_n(rst_n), .addr(addr), .we_n(we_n), .bsel_n(bsel_n),
        .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .adv_ld(adv_ld), .cke_n(cke_n),
        .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out_i), .dq_oe(dq_oe_i));

    function automatic logic [DW-1:0] pat(input int a, input int salt);
        logic [DW-1:0] v;
        for (int l = 0; l < LANES; l++) v[l*9 +: 9] = 9'((a*7 + l*37 + salt*91 + 5) % 512);
        return v;
    endfunction

    function automatic logic [DW-1:0] lmask(input logic [3:0] bs);
        logic [DW-1:0] m;
        for (int l = 0; l < LANES; l++) m[l*9 +: 9] = bs[l] ? 9'h000 : 9'h1FF;
        return m;
    endfunction

    task automatic mw(input int which, input int a, input logic [DW-1:0] d, input logic [3:0] bs);
        logic [DW-1:0] m;
        m = lmask(bs);
        if (which != 1) m_lin[a] = (m_lin[a] & ~m) | (d & m);
        if (which != 0) m_il[a]  = (m_il[a]  & ~m) | (d & m);
    endtask

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cmd(input bit ld, input bit wr, input logic [2:0] cs, input int a, input logic [3:0] bs);
        adv_ld = !ld;
        we_n   = !wr;
        {cs1_n, cs2, cs3_n} = cs;
        addr   = AW'(a);
        bsel_n = bs;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [3:0] prev_bs, bs;
        rst_n = 1'b0; cke_n = 1'b0; oe_n = 1'b0; dq_in = '0;
        cmd(1, 0, 3'b110, 0, 4'hF);
        repeat (3) step();
        chk(!dq_oe_l && !dq_oe_i, "R1 oe in reset", DW'(dq_oe_l), '0);
        rst_n = 1'b1;
        step();
        chk(!dq_oe_l, "R1 oe after reset", DW'(dq_oe_l), '0);

        // full write sweep, data one edge behind address
        for (int a = 0; a < 64; a++) begin
            cmd(1, 1, SEL, a, 4'h0);
            dq_in = (a == 0) ? '0 : pat(a-1, 0);
            step();
            if (a > 0) mw(2, a-1, pat(a-1, 0), 4'h0);
            chk(!dq_oe_l, "R6 write data cycle", DW'(dq_oe_l), '0);
        end
        dq_in = pat(63, 0);
        cmd(1, 0, SEL, 0, 4'h0);
        step();
        mw(2, 63, pat(63, 0), 4'h0);
        chk(dq_oe_l && dq_out_l == m_lin[0], "R4 read 0", dq_out_l, m_lin[0]);
        for (int a = 1; a < 64; a++) begin
            cmd(1, 0, SEL, a, 4'h0);
            step();
            chk(dq_oe_l && dq_out_l == m_lin[a], "R4 read sweep", dq_out_l, m_lin[a]);
            chk(dq_out_i == m_il[a], "R4 read sweep il", dq_out_i, m_il[a]);
        end

        // byte lanes with same-address read right behind the write
        for (int b = 0; b < 16; b++) begin
            cmd(1, 1, SEL, 5, 4'(b));
            step();
            dq_in = pat(b + 1, 3);
            cmd(1, 0, SEL, 5, 4'h0);
            step();
            mw(2, 5, pat(b + 1, 3), 4'(b));
            chk(dq_oe_l && dq_out_l == m_lin[5], "R5 R8 lane merge", dq_out_l, m_lin[5]);
        end

        // stall inside a read
        cmd(1, 0, SEL, 3, 4'h0);
        step();
        cke_n = 1'b1;
        cmd(1, 1, 3'b111, 4, 4'h0);
        step();
        step();
        chk(dq_oe_l && dq_out_l == m_lin[3], "R2 read held", dq_out_l, m_lin[3]);
        cke_n = 1'b0;

        // stall inside a pending write
        cmd(1, 1, SEL, 7, 4'h0);
        step();
        cke_n = 1'b1;
        dq_in = pat(99, 9);
        cmd(1, 0, SEL, 8, 4'h0);
        step();
        chk(!dq_oe_l, "R2 write pending held", DW'(dq_oe_l), '0);
        cke_n = 1'b0;
        dq_in = pat(7, 5);
        cmd(1, 0, SEL, 7, 4'h0);
        step();
        mw(2, 7, pat(7, 5), 4'h0);
        chk(dq_oe_l && dq_out_l == m_lin[7], "R2 write after stall", dq_out_l, m_lin[7]);

        // chip enable decode
        for (int c = 0; c < 8; c++) begin
            cmd(1, 0, 3'(c), 2, 4'h0);
            step();
            chk(dq_oe_l == (3'(c) == SEL), "R3 decode", DW'(dq_oe_l), DW'(3'(c) == SEL));
        end
        cmd(1, 1, 3'b110, 9, 4'h0);
        step();
        dq_in = pat(55, 6);
        cmd(1, 0, SEL, 9, 4'h0);
        step();
        chk(dq_out_l == m_lin[9], "R3 deselected write dropped", dq_out_l, m_lin[9]);

        // asynchronous output enable
        cmd(1, 0, SEL, 4, 4'h0);
        step();
        chk(dq_oe_l, "R7 oe low", DW'(dq_oe_l), DW'(1));
        oe_n = 1'b1; #1;
        chk(!dq_oe_l, "R7 oe high", DW'(dq_oe_l), '0);
        oe_n = 1'b0; #1;
        chk(dq_oe_l, "R7 oe low again", DW'(dq_oe_l), DW'(1));

        // burst read from start 0x11, both orders
        cmd(1, 0, SEL, 6'h11, 4'h0);
        step();
        chk(dq_out_l == m_lin[6'h11] && dq_out_i == m_il[6'h11], "R9 R11 beat0", dq_out_l, m_lin[6'h11]);
        for (int k = 1; k < 4; k++) begin
            int al, ai;
            cmd(0, 1, 3'b111, 6'h3F, 4'h0);
            step();
            al = 6'h10 | ((1 + k) & 3);
            ai = 6'h10 | (1 ^ k);
            chk(dq_oe_l && dq_out_l == m_lin[al], "R9 linear beat", dq_out_l, m_lin[al]);
            chk(dq_oe_i && dq_out_i == m_il[ai], "R11 interleaved beat", dq_out_i, m_il[ai]);
        end

        // burst write from 0x21 with per-beat byte selects
        cmd(1, 1, SEL, 6'h21, 4'h0);
        prev_bs = 4'h0;
        step();
        for (int k = 1; k < 4; k++) begin
            bs = (k == 2) ? 4'b1010 : 4'b0000;
            dq_in = pat(k - 1, 7);
            cmd(0, 0, 3'b111, 0, bs);
            step();
            mw(0, 6'h20 | ((k) & 3), pat(k - 1, 7), prev_bs);
            mw(1, 6'h20 | (1 ^ (k - 1)), pat(k - 1, 7), prev_bs);
            chk(!dq_oe_l, "R6 burst write data", DW'(dq_oe_l), '0);
            prev_bs = bs;
        end
        dq_in = pat(3, 7);
        cmd(1, 0, SEL, 6'h20, 4'h0);
        step();
        mw(0, 6'h20, pat(3, 7), prev_bs);
        mw(1, 6'h22, pat(3, 7), prev_bs);
        chk(dq_out_l == m_lin[6'h20] && dq_out_i == m_il[6'h20], "R9 burst write 20", dq_out_l, m_lin[6'h20]);
        for (int a = 6'h21; a < 6'h24; a++) begin
            cmd(1, 0, SEL, a, 4'h0);
            step();
            chk(dq_out_l == m_lin[a], "R9 burst write linear", dq_out_l, m_lin[a]);
            chk(dq_out_i == m_il[a], "R11 burst write interleaved", dq_out_i, m_il[a]);
        end

        // deselect, then continue edges while deselected
        cmd(1, 0, 3'b000, 6'h23, 4'h0);
        step();
        chk(!dq_oe_l, "R6 deselected", DW'(dq_oe_l), '0);
        cmd(0, 1, SEL, 6'h23, 4'h0);
        step();
        chk(!dq_oe_l, "R10 continue while deselected", DW'(dq_oe_l), '0);
        dq_in = pat(77, 2);
        cmd(0, 0, SEL, 6'h23, 4'h0);
        step();
        chk(!dq_oe_l, "R10 still deselected", DW'(dq_oe_l), '0);
        dq_in = pat(78, 2);
        cmd(1, 0, SEL, 6'h23, 4'h0);
        step();
        chk(dq_oe_l && dq_out_l == m_lin[6'h23], "R10 no array access", dq_out_l, m_lin[6'h23]);

        // reset drops a pending write
        cmd(1, 1, SEL, 6'h30, 4'h0);
        step();
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        chk(!dq_oe_l, "R1 oe after mid reset", DW'(dq_oe_l), '0);
        dq_in = pat(88, 4);
        cmd(1, 0, SEL, 6'h30, 4'h0);
        step();
        chk(dq_out_l == m_lin[6'h30], "R1 pending write dropped", dq_out_l, m_lin[6'h30]);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule